// File: doc/BRIEF.md
# Receive Character Queue with Error Reporting Modes

This block sits between a serial receiver's deserializer and the read side of a host bus. It keeps up to three received characters in arrival order, each with its own parity-error, framing-error and break flags. When all three slots are in use, one more character can wait in a holding slot, which stands in for the shift register. If a further start bit arrives while that character is still waiting, the waiting character is discarded and an overrun is recorded.

The reported error flags follow one of two modes. In per-character mode they belong to the character at the head of the queue. In accumulated mode each flag is the OR of the flags of every character that has reached the head since the last error-clear command. Ready and full indications are provided for the host. An optional flow-control output asks the remote sender to pause when a start bit arrives while the queue is full, and releases it once a slot frees up.

A receiver-flush command realigns the read pointer onto the write pointer. It does not erase stored bytes, so a stale head byte stays visible on the data output.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, `rx_ready`, `fifo_full`, all four status flags and `rts_n` are 0, and the read and write pointers both point to slot 0.
- R2: Pushed characters come out on `rd_data` in arrival order. `rx_ready` is 1 whenever at least one character is stored. A pulse on `rd_pop` removes the head character.
- R3: `fifo_full` is 1 exactly when all three slots hold characters.
- R4: With `block_mode` = 0, `stat_perr`, `stat_ferr` and `stat_brk` show the flags stored with the current head slot.
- R5: With `block_mode` = 1, each status flag is the OR of the flags of every non-empty head since the last `err_clr`, together with the current head's flags.
- R6: A character pushed while all three slots are full waits in a holding slot. It enters the queue on the same edge at which a pop frees a slot.
- R7: A `start_det` pulse while a character is waiting and no slot is freed in that cycle discards the waiting character, leaves the stored characters unchanged, and sets `stat_ovr` on the next edge.
- R8: With `auto_rts` = 1, `rts_n` goes to 1 on the edge after a `start_det` that sees a full queue. It returns to 0 on the edge after the stored count drops below three. With `auto_rts` = 0, `rts_n` stays 0.
- R9: `rx_flush` discards any waiting character, clears `rx_ready` and `fifo_full`, moves the read pointer onto the write pointer and clears the flags of the slot there. It keeps that slot's data byte.
- R10: `err_clr` clears `stat_ovr` and the accumulated flags used in accumulated mode.
- R11: `rd_pop` on an empty queue moves no pointer. `rd_data` keeps showing the stale byte of the head slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Character from the deserializer is valid this cycle |
| push_data | input | 8 | Received data byte |
| push_perr | input | 1 | Parity error of the pushed character |
| push_ferr | input | 1 | Framing error of the pushed character |
| push_brk | input | 1 | Break flag of the pushed character |
| start_det | input | 1 | Pulse: a valid start bit was detected |
| rd_pop | input | 1 | Host data read; pops the head entry |
| err_clr | input | 1 | Error-clear command |
| rx_flush | input | 1 | Receiver-flush command |
| block_mode | input | 1 | 0 = per-character status, 1 = accumulated status |
| auto_rts | input | 1 | Enables automatic flow control on `rts_n` |
| rd_data | output | 8 | Data byte of the head slot |
| rx_ready | output | 1 | At least one character is stored |
| fifo_full | output | 1 | All three slots are occupied |
| stat_perr | output | 1 | Reported parity error |
| stat_ferr | output | 1 | Reported framing error |
| stat_brk | output | 1 | Reported break |
| stat_ovr | output | 1 | Overrun recorded |
| rts_n | output | 1 | Request-to-send, active low (1 asks the sender to pause) |

## Verification
Every command takes effect on the first clock edge after the cycle it is driven in. `rx_ready`, `fifo_full`, `stat_ovr` and `rts_n` are therefore due one edge after a push, pop, start bit or clear. The one exception is the release of `rts_n`, which is due one edge after the count has dropped, so two edges after the pop that caused it. `rd_data` and the status flags in per-character mode follow the head combinationally. The bench therefore checks the byte on `rd_data` in the same cycle it asserts the pop. It drives inputs on the falling edge and samples outputs on a later falling edge, so each check lands half a cycle after the edge that produced its result.

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              start_det,
  input  logic              rd_pop,
  input  logic              err_clr,
  input  logic              rx_flush,
  input  logic              block_mode,
  input  logic              auto_rts,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              fifo_full,
  output logic              stat_perr,
  output logic              stat_ferr,
  output logic              stat_brk,
  output logic              stat_ovr,
  output logic              rts_n
);
  localparam int EW = DATA_W + 3;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [EW-1:0] slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          hold_v;
  logic [EW-1:0] hold_e;
  logic [2:0]    acc;
  logic          ovr_q, rts_q;

  wire [EW-1:0] in_e      = {push_brk, push_ferr, push_perr, push_data};
  wire [EW-1:0] head_e    = slots[rd_ptr];
  wire [2:0]    head_fl   = head_e[EW-1:DATA_W];
  wire          not_empty = (count != '0);
  wire          is_full   = (count == FULL_CNT);
  wire          pop_en    = rd_pop && not_empty && !rx_flush;
  wire          room      = !is_full || pop_en;
  wire          wr_en     = !rx_flush && room && (hold_v || push);
  wire [EW-1:0] wr_e      = hold_v ? hold_e : in_e;
  wire          ovr_hit   = start_det && hold_v && !room;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (rx_flush) begin
      rd_ptr <= wr_ptr;
      count  <= '0;
      slots[wr_ptr][EW-1:DATA_W] <= '0;
    end else begin
      if (wr_en) begin
        slots[wr_ptr] <= wr_e;
        wr_ptr <= bump(wr_ptr);
      end
      if (pop_en) rd_ptr <= bump(rd_ptr);
      if (wr_en && !pop_en) count <= count + 1'b1;
      else if (!wr_en && pop_en) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_e <= '0;
    end else if (rx_flush) begin
      hold_v <= 1'b0;
    end else if (push && (hold_v || !room)) begin
      hold_v <= 1'b1;
      hold_e <= in_e;
    end else if (wr_en || ovr_hit) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      ovr_q <= 1'b0;
      rts_q <= 1'b0;
    end else begin
      acc   <= err_clr ? 3'b000 : (acc | (not_empty ? head_fl : 3'b000));
      ovr_q <= (ovr_q && !err_clr) || ovr_hit;
      if (start_det && is_full) rts_q <= 1'b1;
      else if (!is_full)        rts_q <= 1'b0;
    end
  end

  wire [2:0] rep_fl = block_mode ? (acc | (not_empty ? head_fl : 3'b000)) : head_fl;

  assign rd_data   = head_e[DATA_W-1:0];
  assign rx_ready  = not_empty;
  assign fifo_full = is_full;
  assign stat_perr = rep_fl[0];
  assign stat_ferr = rep_fl[1];
  assign stat_brk  = rep_fl[2];
  assign stat_ovr  = ovr_q;
  assign rts_n     = auto_rts && rts_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);  // R3
  AST_FULL_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rx_ready);  // R3
  AST_EMPTY_POP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !rx_ready && !rx_flush) |=> $stable(rd_ptr));  // R11
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && hold_v && fifo_full && !rd_pop) |=> stat_ovr);  // R7
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && hold_v && fifo_full && !rd_pop && !rx_flush && !push) |=> ($stable(count) && !hold_v));  // R7
  AST_RTS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts && start_det && fifo_full) ##1 auto_rts |-> rts_n);  // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (!rx_ready && !hold_v));  // R9
  AST_ERRCLR_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(start_det && hold_v)) |=> !stat_ovr);  // R10
endmodule

// File: tb/tb_rx_char_queue.sv
`timescale 1ns/1ps
module tb_rx_char_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 0, push_perr = 0, push_ferr = 0, push_brk = 0;
  logic [7:0] push_data = '0;
  logic start_det = 0, rd_pop = 0, err_clr = 0, rx_flush = 0, block_mode = 0, auto_rts = 0;
  logic [7:0] rd_data;
  logic rx_ready, fifo_full, stat_perr, stat_ferr, stat_brk, stat_ovr, rts_n;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_char_queue dut (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
    .start_det(start_det), .rd_pop(rd_pop), .err_clr(err_clr), .rx_flush(rx_flush),
    .block_mode(block_mode), .auto_rts(auto_rts), .rd_data(rd_data),
    .rx_ready(rx_ready), .fifo_full(fifo_full), .stat_perr(stat_perr),
    .stat_ferr(stat_ferr), .stat_brk(stat_brk), .stat_ovr(stat_ovr), .rts_n(rts_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    {push, push_perr, push_ferr, push_brk, start_det, rd_pop, err_clr, rx_flush} = '0;
    block_mode = 0; auto_rts = 0; push_data = '0;
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, input logic p, input logic f, input logic b);
    push = 1; push_data = d; push_perr = p; push_ferr = f; push_brk = b;
    @(negedge clk);
    push = 0; push_perr = 0; push_ferr = 0; push_brk = 0;
  endtask

  task automatic take(input string tag, input logic [7:0] exp);
    chk(tag, rd_data, exp);
    rd_pop = 1;
    @(negedge clk);
    rd_pop = 0;
  endtask

  task automatic pulse_start();
    start_det = 1; @(negedge clk); start_det = 0;
  endtask

  task automatic pulse_errclr();
    err_clr = 1; @(negedge clk); err_clr = 0;
  endtask

  task automatic pulse_flush();
    rx_flush = 1; @(negedge clk); rx_flush = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 fifo_full", fifo_full, 0);
    chk("R1 status", {stat_perr, stat_ferr, stat_brk, stat_ovr}, 0);
    chk("R1 rts_n", rts_n, 0);
  endtask

  task automatic t_order();
    do_reset();
    put(8'h11, 0, 0, 0);
    chk("R2 ready after push", rx_ready, 1);
    put(8'h22, 0, 0, 0);
    chk("R3 not full at two", fifo_full, 0);
    take("R2 first", 8'h11);
    take("R2 second", 8'h22);
    chk("R2 ready after drain", rx_ready, 0);
  endtask

  task automatic t_full_char_mode();
    do_reset();
    put(8'hA1, 1, 0, 0);
    put(8'hB2, 0, 1, 0);
    put(8'hC3, 0, 0, 1);
    chk("R3 full at three", fifo_full, 1);
    chk("R4 head flags A", {stat_brk, stat_ferr, stat_perr}, 3'b001);
    take("R2 A", 8'hA1);
    chk("R3 not full after pop", fifo_full, 0);
    chk("R4 head flags B", {stat_brk, stat_ferr, stat_perr}, 3'b010);
    take("R2 B", 8'hB2);
    chk("R4 head flags C", {stat_brk, stat_ferr, stat_perr}, 3'b100);
    take("R2 C", 8'hC3);
  endtask

  task automatic t_block_mode();
    do_reset();
    block_mode = 1;
    put(8'h01, 1, 0, 0);
    put(8'h02, 0, 0, 1);
    @(negedge clk);
    take("R5 first", 8'h01);
    @(negedge clk);
    take("R5 second", 8'h02);
    @(negedge clk);
    chk("R5 accumulated flags", {stat_brk, stat_ferr, stat_perr}, 3'b101);
    pulse_errclr();
    chk("R10 accumulated cleared", {stat_brk, stat_ferr, stat_perr}, 3'b000);
  endtask

  task automatic t_hold_drain();
    do_reset();
    put(8'h10, 0, 0, 0);
    put(8'h20, 0, 0, 0);
    put(8'h30, 0, 0, 0);
    put(8'h40, 0, 0, 0);
    chk("R6 still full with holder", fifo_full, 1);
    take("R6 h1", 8'h10);
    chk("R6 refilled from hold", fifo_full, 1);
    take("R6 h2", 8'h20);
    take("R6 h3", 8'h30);
    take("R6 held char", 8'h40);
    chk("R6 empty", rx_ready, 0);
  endtask

  task automatic t_overrun();
    do_reset();
    put(8'h51, 0, 0, 0);
    put(8'h52, 0, 0, 0);
    put(8'h53, 0, 0, 0);
    put(8'h54, 0, 0, 0);
    chk("R7 no overrun yet", stat_ovr, 0);
    pulse_start();
    chk("R7 overrun set", stat_ovr, 1);
    take("R7 o1", 8'h51);
    take("R7 o2", 8'h52);
    take("R7 o3", 8'h53);
    chk("R7 held char lost", rx_ready, 0);
    pulse_errclr();
    chk("R10 overrun cleared", stat_ovr, 0);
  endtask

  task automatic t_rts();
    do_reset();
    put(8'h61, 0, 0, 0);
    put(8'h62, 0, 0, 0);
    put(8'h63, 0, 0, 0);
    pulse_start();
    chk("R8 rts_n disabled", rts_n, 0);
    auto_rts = 1;
    pulse_start();
    chk("R8 rts_n pause", rts_n, 1);
    take("R8 pop", 8'h61);
    @(negedge clk);
    chk("R8 rts_n resume", rts_n, 0);
  endtask

  task automatic t_flush_and_empty_read();
    do_reset();
    put(8'h71, 1, 0, 0);
    put(8'h72, 0, 0, 0);
    put(8'h73, 0, 0, 0);
    put(8'h74, 0, 0, 0);
    pulse_flush();
    chk("R9 ready cleared", rx_ready, 0);
    chk("R9 full cleared", fifo_full, 0);
    chk("R9 data kept", rd_data, 8'h71);
    chk("R9 head flags cleared", stat_perr, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 held char dropped", rx_ready, 0);
    rd_pop = 1; @(negedge clk); rd_pop = 0;
    chk("R11 stale data", rd_data, 8'h71);
    chk("R11 still empty", rx_ready, 0);
    put(8'h7F, 0, 0, 0);
    take("R11 pointers unmoved", 8'h7F);
  endtask

  initial begin
    t_reset_state();
    t_order();
    t_full_char_mode();
    t_block_mode();
    t_hold_drain();
    t_overrun();
    t_rts();
    t_flush_and_empty_read();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule